// File: doc/BRIEF.md
# Debug Freeze Coordinator

This block takes a single synchronous debug freeze request and turns it into three separate stop controls. A main sequencer, a DMA bus master and a bank of general timers each stop at their own safe point. The sequencer gets a halt level one clock after the request is sampled. The DMA engine is barred from starting new bus cycles straight away. The bus is released only after any transfer already in flight has seen its data acknowledge. Each timer has its own enable bit. Timers whose bit is set receive a count/capture hold strobe one clock after the sequencer halt.

The request is ignored while reset is active. Raising it during reset is a usage error, and the design flags that case. When the request drops, the sequencer resumes first, the timers one clock later, and the DMA may compete for the bus again.

Top module: `freeze_fanout`

## Requirements
- R1: `seq_halt` is high in cycle t+1 exactly when `frz_req` was high in cycle t with reset inactive, so halt starts one cycle after the request and ends one cycle after it drops.
- R2: During synchronous reset (`rst_n` low) and in the first cycle after it, `seq_halt`, `dma_bus_release` and every bit of `tmr_hold` are low; `frz_req` must be low throughout reset.
- R3: `dma_start_inhibit` is high in any cycle where `frz_req` is high, and also in the cycle after a cycle where `frz_req` was high.
- R4: If `dma_busy` is high and `bus_ack` low when the request is sampled, `dma_bus_release` stays low until the cycle after the cycle in which `bus_ack` is high.
- R5: If no bus cycle is open (`dma_busy` low), or `bus_ack` is high in the cycle the request is sampled, `dma_bus_release` rises in the next cycle.
- R6: `dma_bus_release` falls in the cycle after `frz_req` goes low. If the request drops before the pending acknowledge, no release is issued at all.
- R7: `tmr_hold[i]` is high in cycle t+1 exactly when `seq_halt` and `tmr_frz_en[i]` were both high in cycle t, so an enabled timer holds one cycle after the sequencer halt.
- R8: A timer whose `tmr_frz_en` bit was low in the previous cycle never has its hold strobe high.
- R9: `dma_bus_release` never rises while a bus cycle was open without acknowledge in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frz_req | input | 1 | Synchronous debug freeze request |
| tmr_frz_en | input | NUM_TMR | Per-timer freeze enable bits from configuration |
| dma_busy | input | 1 | DMA bus cycle in progress |
| bus_ack | input | 1 | Bus data acknowledge for the open cycle |
| seq_halt | output | 1 | Halt level to the main sequencer |
| dma_start_inhibit | output | 1 | Forbids the DMA from starting a new bus cycle |
| dma_bus_release | output | 1 | Requests the DMA to give up bus ownership |
| tmr_hold | output | NUM_TMR | Per-timer count/capture hold strobes |

## Verification
The bench builds the block with NUM_TMR at 3. That gives enough timers to mix enabled and disabled lanes in one run, and to change the mask while a freeze is held. A DMA stub opens bus cycles whenever it is allowed to. This lets random acknowledge delays fall before, during and after freeze windows, including one-cycle pulses that end before the acknowledge arrives.

// File: rtl/freeze_fanout_pkg.sv
// Shared types for the debug freeze coordinator.
package freeze_fanout_pkg;

    // DMA freeze handshake states
    typedef enum logic [1:0] {
        DMA_RUN   = 2'd0,   // normal operation
        DMA_DRAIN = 2'd1,   // freeze seen, waiting for acknowledge of open cycle
        DMA_HELD  = 2'd2    // bus released, held while freeze persists
    } dma_frz_e;

endpackage

// File: rtl/freeze_halt_stage.sv
// Sequencer halt stage.
// Registers the qualified freeze request once, giving a halt level that
// follows the request by exactly one clock.
// Assumes frz_eff is already forced low during reset.
module freeze_halt_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic frz_eff,
    output logic seq_halt
);

    // One-clock delay of the qualified request
    always_ff @(posedge clk) begin
        if (!rst_n) seq_halt <= 1'b0;
        else        seq_halt <= frz_eff;
    end

    assert_halt_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frz_eff |=> seq_halt);
    assert_halt_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frz_eff |=> !seq_halt);

endmodule

// File: rtl/freeze_dma_ctl.sv
// DMA freeze handshake.
// Blocks new bus cycles while freeze is requested. An open cycle is allowed
// to reach its acknowledge before bus release is requested. A request that
// vanishes before the acknowledge produces no release.
// Assumes cyc_open falls on the edge where bus_ack is sampled high.
module freeze_dma_ctl
    import freeze_fanout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frz_eff,
    input  logic cyc_open,
    input  logic bus_ack,
    output logic start_inhibit,
    output logic bus_release
);

    dma_frz_e state_q, state_d;

    // Next-state selection for the handshake
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DMA_RUN: begin
                if (frz_eff) begin
                    if (cyc_open && !bus_ack) state_d = DMA_DRAIN;
                    else                      state_d = DMA_HELD;
                end
            end
            DMA_DRAIN: begin
                if (!frz_eff)     state_d = DMA_RUN;
                else if (bus_ack) state_d = DMA_HELD;
            end
            DMA_HELD: begin
                if (!frz_eff) state_d = DMA_RUN;
            end
            default: state_d = DMA_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DMA_RUN;
        else        state_q <= state_d;
    end

    // Output decode: inhibit immediately and until the handshake returns to run
    always_comb begin
        start_inhibit = frz_eff || (state_q != DMA_RUN);
        bus_release   = (state_q == DMA_HELD);
    end

    assert_inhibit_on_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frz_eff |-> start_inhibit);
    assert_no_release_before_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_release) |-> ($past(bus_ack) || !$past(cyc_open)));
    assert_release_needs_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_release |-> $past(frz_eff));

endmodule

// File: rtl/freeze_timer_gate.sv
// Per-timer hold strobes.
// Each lane takes the sequencer halt stage, masks it with the lane's enable
// bit and registers it, so enabled timers stop one clock after the sequencer.
// Assumes the enable bits are synchronous to clk.
module freeze_timer_gate #(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_stage,
    input  logic [NUM_TMR-1:0] frz_en,
    output logic [NUM_TMR-1:0] tmr_hold
);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_lane
        // Masked, delayed hold for timer i
        always_ff @(posedge clk) begin
            if (!rst_n) tmr_hold[i] <= 1'b0;
            else        tmr_hold[i] <= halt_stage && frz_en[i];
        end

        assert_disabled_never_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_hold[i] |-> $past(frz_en[i]));
        assert_enabled_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (halt_stage && frz_en[i]) |=> tmr_hold[i]);
    end

endmodule

// File: rtl/freeze_fanout.sv
// Debug freeze coordinator top.
// Qualifies the freeze request with reset and fans it out to the sequencer
// halt stage, the DMA handshake and the timer hold lanes.
// Assumes frz_req is synchronous to clk and held low during reset.
module freeze_fanout #(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frz_req,
    input  logic [NUM_TMR-1:0] tmr_frz_en,
    input  logic               dma_busy,
    input  logic               bus_ack,
    output logic               seq_halt,
    output logic               dma_start_inhibit,
    output logic               dma_bus_release,
    output logic [NUM_TMR-1:0] tmr_hold
);

    logic frz_eff;

    // Request counts only outside reset
    always_comb frz_eff = frz_req && rst_n;

    freeze_halt_stage u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .frz_eff  (frz_eff),
        .seq_halt (seq_halt)
    );

    freeze_dma_ctl u_dma (
        .clk           (clk),
        .rst_n         (rst_n),
        .frz_eff       (frz_eff),
        .cyc_open      (dma_busy),
        .bus_ack       (bus_ack),
        .start_inhibit (dma_start_inhibit),
        .bus_release   (dma_bus_release)
    );

    freeze_timer_gate #(.NUM_TMR(NUM_TMR)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_stage (seq_halt),
        .frz_en     (tmr_frz_en),
        .tmr_hold   (tmr_hold)
    );

    // Usage check: freeze must be quiet while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_frz_low_in_reset_R2: assert (!frz_req)
                else $error("freeze request high during reset");
        end
    end

endmodule

// File: tb/freeze_fanout_test.sv
module freeze_fanout_test;
    localparam int N      = 3;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frz_req = 1'b0;
    logic [N-1:0] tmr_frz_en = '0;
    logic         dma_busy = 1'b0;
    logic         bus_ack = 1'b0;
    logic         seq_halt, dma_start_inhibit, dma_bus_release;
    logic [N-1:0] tmr_hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit         m_halt, m_rel;
    bit [N-1:0] m_hold;
    bit [N-1:0] m_en_prev;
    int         tcnt [N];
    int         tcnt_exp [N];

    freeze_fanout #(.NUM_TMR(N)) uut (
        .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .tmr_frz_en(tmr_frz_en),
        .dma_busy(dma_busy), .bus_ack(bus_ack), .seq_halt(seq_halt),
        .dma_start_inhibit(dma_start_inhibit), .dma_bus_release(dma_bus_release),
        .tmr_hold(tmr_hold)
    );

    always #(PERIOD/2) clk = ~clk;

    // timer stubs: count unless held
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++)
            if (!tmr_hold[i]) tcnt[i] <= tcnt[i] + 1;
    end

    function automatic bit exp_release(bit f, bit rel, bit open, bit ack);
        return f && (rel || !open || ack);
    endfunction

    function automatic bit [N-1:0] exp_hold(bit halt, bit [N-1:0] en);
        return halt ? en : '0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, let posedge occur, check at next negedge
    task automatic step(bit f, bit [N-1:0] en, bit ack_i, bit want);
        bit         n_halt, n_rel, busy_n;
        bit [N-1:0] n_hold;
        frz_req    = f;
        tmr_frz_en = en;
        bus_ack    = ack_i && dma_busy;
        #1;
        chk(dma_start_inhibit == (f || m_halt), "R3", dma_start_inhibit, f || m_halt);
        n_halt = f;
        n_rel  = exp_release(f, m_rel, dma_busy, bus_ack);
        n_hold = exp_hold(m_halt, en);
        busy_n = dma_busy ? !bus_ack : (want && !dma_start_inhibit);
        for (int i = 0; i < N; i++) if (!m_hold[i]) tcnt_exp[i]++;
        @(posedge clk);
        @(negedge clk);
        if (n_rel && !m_rel)
            chk(!(dma_busy && !bus_ack), "R9", dma_busy, 0);
        m_halt = n_halt; m_rel = n_rel; m_hold = n_hold; m_en_prev = en;
        dma_busy = busy_n;
        chk(seq_halt == m_halt, "R1", seq_halt, m_halt);
        chk(dma_bus_release == m_rel, "R4 R5 R6 release", dma_bus_release, m_rel);
        chk(tmr_hold == m_hold, "R7", tmr_hold, m_hold);
        chk((tmr_hold & ~m_en_prev) == '0, "R8", tmr_hold, 0);
        for (int i = 0; i < N; i++)
            chk(tcnt[i] == tcnt_exp[i], "R7 R8 timer count", tcnt[i], tcnt_exp[i]);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit f;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin tcnt[i] = 0; tcnt_exp[i] = 0; end
        m_halt = 0; m_rel = 0; m_hold = '0; m_en_prev = '0;
        // reset with busy and enables active, freeze low (R2)
        dma_busy = 1'b1; tmr_frz_en = '1;
        repeat (3) @(negedge clk);
        chk(seq_halt == 0 && dma_bus_release == 0 && tmr_hold == '0, "R2 in reset",
            {seq_halt, dma_bus_release, tmr_hold}, 0);
        rst_n = 1'b1;
        dma_busy = 1'b0;
        for (int i = 0; i < N; i++) begin tcnt_exp[i] = tcnt[i]; end
        step(0, '1, 0, 0);
        chk(seq_halt == 0 && dma_bus_release == 0 && tmr_hold == '0, "R2 after reset",
            {seq_halt, dma_bus_release, tmr_hold}, 0);

        // idle freeze, mixed mask: release next cycle (R5)
        step(1, 3'b101, 0, 0);
        chk(dma_bus_release == 1, "R5 idle release", dma_bus_release, 1);
        step(1, 3'b101, 0, 0);
        chk(tmr_hold == 3'b101, "R7 enabled lanes", tmr_hold, 3'b101);
        step(0, 3'b101, 0, 0);
        chk(dma_bus_release == 0, "R6 release drop", dma_bus_release, 0);
        step(0, 3'b101, 0, 0);

        // open a cycle, freeze, ack after three cycles (R4)
        step(0, 3'b010, 0, 1);
        chk(dma_busy == 1, "R4 setup", dma_busy, 1);
        step(1, 3'b010, 0, 0);
        step(1, 3'b010, 0, 0);
        chk(dma_bus_release == 0, "R4 wait for ack", dma_bus_release, 0);
        step(1, 3'b010, 1, 0);
        chk(dma_bus_release == 1, "R4 release after ack", dma_bus_release, 1);
        step(0, 3'b010, 0, 0);
        step(0, 3'b010, 0, 0);

        // single-cycle pulse while a cycle is open: no release (R6)
        step(0, '0, 0, 1);
        step(1, '0, 0, 0);
        step(0, '0, 0, 0);
        chk(dma_bus_release == 0, "R6 no spurious release", dma_bus_release, 0);
        step(0, '0, 1, 0);
        chk(dma_bus_release == 0, "R6 no late release", dma_bus_release, 0);

        // ack in same cycle as freeze sample (R5)
        step(0, '1, 0, 1);
        step(1, '1, 1, 0);
        chk(dma_bus_release == 1, "R5 ack with freeze", dma_bus_release, 1);
        step(1, 3'b000, 0, 0);
        step(1, 3'b000, 0, 0);
        chk(tmr_hold == '0, "R8 mask cleared while frozen", tmr_hold, 0);
        step(0, '0, 0, 0);

        // random traffic
        f = 0;
        for (int c = 0; c < 4000; c++) begin
            bit [N-1:0] en;
            if (($urandom % 8) == 0) f = !f;
            en = (c % 64 == 0) ? N'($urandom) : tmr_frz_en;
            step(f, en, ($urandom % 3) == 0, ($urandom % 2) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule